// File: doc/BRIEF.md
# Pipelined Split-Address AES Byte Substitution

This block applies the forward AES byte substitution to one byte per cycle. It is shared by the round datapath and the round-key generator. A flat 256-entry lookup has a long decode path. Here the input byte is split into a low field and a high field instead. The low field addresses a row of small distributed tables in parallel, each table holding the entries for one value of the high field. All partial results are captured in a register, together with the high field. In the next stage the registered high field picks the right partial result, and that result is registered at the output.

The byte stream flows through a valid/ready interface on both sides. A transfer happens on a rising edge where valid and ready are both high. The two pipeline stages advance together. If the output holds a result that the consumer has not taken (`out_ready` low), the whole pipe freezes and `in_ready` drops in the same cycle. When the output register is empty, or is being drained in that cycle, a new byte is accepted. Results always leave in the order the bytes arrived.

Top module: `sbox_split_pipe`

## Requirements
- R1: While `rst_n` is low and after its release, before any input is accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: Each output byte equals the forward AES substitution of the byte it came from, for all 256 values (for example 00 gives 63, 53 gives ED, FF gives 16, all hex).
- R3: With `out_ready` held high, a byte presented with `in_valid` in cycle n is delivered with `out_valid` high in cycle n+2 (two register stages).
- R4: Results leave in the same order the bytes were accepted, with no loss and no duplication.
- R5: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` stays 1 and `out_byte` is unchanged.
- R6: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R7: With `out_ready` held high, bytes accepted on consecutive cycles are delivered on consecutive cycles (one result per cycle).
- R8: A cycle with `in_valid` low creates no result. `out_valid` never rises without a matching accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
The interesting collision is a new byte entering on the same edge that a stalled result finally drains. The bench drives `in_valid` into a frozen pipe and releases `out_ready` in that same cycle. It also toggles `out_ready` in an irregular pattern while it feeds bytes with random gaps. A scoreboard then checks that every result shows up exactly once, in order and with the right value. It also checks that a held result keeps its byte through every stalled cycle.

// File: rtl/sbox_split_pkg.sv
package sbox_split_pkg;

  localparam int BYTE_W = 8;

  // GF(2^8) product modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] ex;
    r    = 8'h01;
    base = a;
    ex   = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/sbox_subtable.sv
module sbox_subtable
  import sbox_split_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_VAL = 0
) (
  input  logic [LO_W-1:0] lo,
  output logic [7:0]      val
);
  localparam int ENTRIES = 2 ** LO_W;

  logic [7:0] tbl [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [7:0] ENT = sbox_fwd(8'(HI_VAL * ENTRIES + e));
    assign tbl[e] = ENT;
  end

  assign val = tbl[lo];
endmodule

// File: rtl/sbox_split_stage.sv
module sbox_split_stage
  import sbox_split_pkg::*;
#(
  parameter int LO_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          in_valid,
  input  logic [BYTE_W-1:0]             in_byte,
  output logic                          s1_valid,
  output logic [BYTE_W-LO_W-1:0]        s1_hi,
  output logic [2**(BYTE_W-LO_W)-1:0][7:0] s1_part
);
  localparam int HI_W    = BYTE_W - LO_W;
  localparam int NUM_SUB = 2 ** HI_W;

  logic [NUM_SUB-1:0][7:0] part_c;

  for (genvar h = 0; h < NUM_SUB; h++) begin : g_sub
    sbox_subtable #(.LO_W(LO_W), .HI_VAL(h)) u_tab (
      .lo  (in_byte[LO_W-1:0]),
      .val (part_c[h])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hi    <= '0;
      s1_part  <= '0;
    end else if (en) begin
      s1_valid <= in_valid;
      s1_hi    <= in_byte[BYTE_W-1:LO_W];
      s1_part  <= part_c;
    end
  end
endmodule

// File: rtl/sbox_select_stage.sv
module sbox_select_stage
  import sbox_split_pkg::*;
#(
  parameter int LO_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             s1_valid,
  input  logic [BYTE_W-LO_W-1:0]           s1_hi,
  input  logic [2**(BYTE_W-LO_W)-1:0][7:0] s1_part,
  output logic                             out_valid,
  output logic [7:0]                       out_byte
);
  logic [7:0] pick;
  assign pick = s1_part[s1_hi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
    end else if (en) begin
      out_valid <= s1_valid;
      out_byte  <= pick;
    end
  end
endmodule

// File: rtl/sbox_split_pipe.sv
module sbox_split_pipe
  import sbox_split_pkg::*;
#(
  parameter int LO_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);
  localparam int HI_W    = BYTE_W - LO_W;
  localparam int NUM_SUB = 2 ** HI_W;

  logic                    adv;
  logic                    s1_valid;
  logic [HI_W-1:0]         s1_hi;
  logic [NUM_SUB-1:0][7:0] s1_part;

  // the whole pipe moves only when the output slot frees up
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  sbox_split_stage #(.LO_W(LO_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (adv),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .s1_valid (s1_valid),
    .s1_hi    (s1_hi),
    .s1_part  (s1_part)
  );

  sbox_select_stage #(.LO_W(LO_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .s1_valid  (s1_valid),
    .s1_hi     (s1_hi),
    .s1_part   (s1_part),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );
endmodule

// File: rtl/sbox_split_chk.sv
module sbox_split_chk
  import sbox_split_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  // shadow tracking of accepted bytes, driven only from the ports
  logic       sh1_v, sh2_v;
  logic [7:0] sh1_b, sh2_b;
  logic       move;
  assign move = !sh2_v || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh1_v <= 1'b0; sh2_v <= 1'b0; sh1_b <= 8'h00; sh2_b <= 8'h00;
    end else if (move) begin
      sh1_v <= in_valid; sh1_b <= in_byte;
      sh2_v <= sh1_v;    sh2_b <= sh1_b;
    end
  end

  // R8 / R4: output valid only as the tracked accepted stream says
  a_r8_valid_track: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh2_v);

  // R2: value matches substitution of the tracked byte
  a_r2_value: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_byte == sbox_fwd(sh2_b));

  // R5: stalled output holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R6: ready follows output slot state
  a_r6_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R1: empty right after reset
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind sbox_split_pipe sbox_split_chk u_chk (.*);

// File: tb/sim_sbox_split_pipe.sv
module sim_sbox_split_pipe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [7:0] ref_tab [256];
  logic [7:0] exq [$];
  int         cq  [$];
  bit         lq  [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sbox_split_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference built from log/antilog tables and a bitwise affine step
  task automatic build_ref();
    int ex [256];
    int lg [256];
    int v;
    v = 1;
    for (int i = 0; i < 255; i++) begin
      ex[i] = v; lg[v] = i;
      v = v ^ ((v << 1) ^ (((v >> 7) & 1) ? 'h11b : 0));
      v = v & 'hff;
    end
    for (int a = 0; a < 256; a++) begin
      int inv;
      logic [7:0] b, r;
      inv = (a == 0) ? 0 : ex[(255 - lg[a]) % 255];
      b = 8'(inv);
      for (int i = 0; i < 8; i++)
        r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
      ref_tab[a] = r;
    end
  endtask

  // drive one byte (gap cycles of idle first); latency check if lat set
  task automatic send(input logic [7:0] b, input int gap, input bit lat);
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1 in_valid = 1'b0;
    end
    @(posedge clk); #1 in_valid = 1'b1; in_byte = b;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        exq.push_back(ref_tab[b]); cq.push_back(cyc); lq.push_back(lat);
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic [7:0] held_b;
  bit         held = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (held) begin
        chk("R5 held valid", out_valid, 1);
        chk("R5 held byte", out_byte, held_b);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin held = 1'b1; held_b = out_byte; end
      if ((cyc % 7) == 0) chk("R6 ready rule", in_ready, (!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exq.size() == 0) begin
          chk("R8 spurious output", 1, 0);
        end else begin
          logic [7:0] e; int c0; bit l;
          e = exq.pop_front(); c0 = cq.pop_front(); l = lq.pop_front();
          chk("R2 R4 value in order", out_byte, e);
          if (l) chk("R3 R7 latency", cyc - c0, 2);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    build_ref();
    chk("R2 ref 00", ref_tab[8'h00], 8'h63);
    chk("R2 ref 53", ref_tab[8'h53], 8'hED);
    chk("R2 ref FF", ref_tab[8'hFF], 8'h16);
    #2;
    chk("R1 reset out_valid", out_valid, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset out_valid", out_valid, 0);
    chk("R1 after reset in_ready", in_ready, 1);

    // R7 R3: full sweep back to back
    for (int a = 0; a < 256; a++) send(8'(a), 0, 1'b1);
    idle();
    repeat (4) @(posedge clk);

    // R8: gaps produce nothing extra; lone byte latency R3
    send(8'h53, 3, 1'b1);
    idle();
    repeat (5) @(posedge clk);
    chk("R8 queue drained", exq.size(), 0);

    // R5 R6: irregular back-pressure with random gaps
    fork
      begin
        for (int k = 0; k < 200; k++) send(8'($urandom), $urandom_range(0, 2), 1'b0);
        idle();
      end
      begin
        for (int k = 0; k < 900; k++) begin
          @(posedge clk); #1 out_ready = ($urandom_range(0, 2) != 0);
        end
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join
    repeat (6) @(posedge clk);

    // same-cycle collision: stall full pipe, release ready with new input
    @(posedge clk); #1 out_ready = 1'b0;
    send(8'h00, 0, 1'b0);
    send(8'h01, 0, 1'b0);
    @(posedge clk); #1 in_valid = 1'b1; in_byte = 8'hC9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 stalled in_ready", in_ready, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk);
    chk("R6 release in_ready", in_ready, 1);
    exq.push_back(ref_tab[8'hC9]); cq.push_back(cyc); lq.push_back(1'b0);
    idle();
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R4 R8 all results delivered", exq.size(), 0);
    chk("R8 idle output", out_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule